// File: doc/BRIEF.md
# Serial Programming Slave

This block is the device side of a four-byte serial programming link. A host drives a serial clock and a data line into the block and reads a data line back. Each instruction is four bytes long. The first byte selects the operation. The middle two bytes carry an address. The last byte carries write data on the way in, or read data on the way out. The block keeps two small arrays: a program store of 16-bit words, addressed one byte half at a time, and a byte-wide data store.

The serial clock is oversampled by the system clock, so each of its phases must last more than two system clocks. Instructions are refused until the host has completed an enable instruction, whose sync byte the block echoes back. A write keeps its location busy for a fixed number of system clocks. During that window a read of the same location returns all-ones, so the host can poll for completion.

Top module: `isp_slave`

## Requirements
- R1: An instruction is exactly four bytes, sampled MSB first on rising serial-clock edges. It takes effect only after its fourth byte, and all four bytes must be shifted even when the enable handshake fails (first byte 0xAC with any second byte other than 0x53 or 0x80 does nothing).
- R2: The serial output changes only after a falling serial-clock edge. Each outgoing byte's MSB is presented on the falling edge before that byte's first rising edge.
- R3: The enable instruction is 0xAC 0x53 xx xx. While its third byte is shifted in, the output returns 0x53. Completing it unlocks the block.
- R4: Until unlocked, every instruction other than enable is ignored: writes and erase leave both stores unchanged, and reads return 0x00 in byte 4.
- R5: Erase is 0xAC 0x80 xx xx. It sets every program word to 0xFFFF and every data byte to 0xFF.
- R6: A program read has first byte 0b0010_H000. Its word address is byte 2 bits [2:0] (high bits) followed by byte 3. H=1 selects bits [15:8] of the word and H=0 selects bits [7:0]. The byte is returned during byte 4.
- R7: A program write has first byte 0b0100_H000, with the same address and H meaning as R6 and the data in byte 4. Only the selected half of the word changes.
- R8: A data read uses first byte 0xA0 and a data write uses 0xC0. The address is byte 3, and byte 4 carries the data.
- R9: For WR_CYCLES system clocks after a write completes, a read of the same store, address and half returns 0xFF. Other locations read normally. After the window ends, the written value is returned.
- R10: While en_i is low, a partly received instruction is discarded, the shift state is cleared, and the block returns to the locked state.
- R11: Output bytes with nothing to return are 0x00 (bytes 1 and 2, byte 3 except during enable, and byte 4 of non-reads). The output is 0 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, oversamples the serial clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Link enable; low clears instruction state and lock |
| sck_i | input | 1 | Serial clock from the host |
| mosi_i | input | 1 | Serial data from the host |
| miso_o | output | 1 | Serial data to the host |

## Verification
The assertions watch the serial framing on every cycle. The output may move only after a detected falling edge, and the byte counter may advance only on the eighth rising edge. They also check that the unlock comes from a completed enable instruction, that a busy window opens only when unlocked, and that the window counts down one per clock. Whether the right byte comes back depends on store contents and ordering, so only the bench scenarios can show it. This covers the echo value, erase results, half-word selection, polled 0xFF versus the final value, and refusal while locked.

// File: rtl/isp_pkg.sv
package isp_pkg;
  localparam int unsigned BYTE_W    = 8;
  localparam int unsigned INSTR_LEN = 4;
  localparam int unsigned BIT_CW    = $clog2(BYTE_W);
  localparam int unsigned IDX_W     = $clog2(INSTR_LEN);

  typedef logic [BYTE_W-1:0] byte_t;
  typedef byte_t [INSTR_LEN-1:0] instr_t;

  localparam byte_t PFX_CTRL  = 8'hAC;
  localparam byte_t SYNC_BYTE = 8'h53;
  localparam byte_t ERASE_SEL = 8'h80;
  localparam byte_t RD_DATA   = 8'hA0;
  localparam byte_t WR_DATA   = 8'hC0;

  typedef enum logic [2:0] {
    OP_NONE, OP_ENABLE, OP_ERASE, OP_RD_PROG, OP_WR_PROG, OP_RD_DATA, OP_WR_DATA
  } op_e;

  function automatic op_e decode_op(byte_t b0, byte_t b1);
    op_e op = OP_NONE;
    if (b0 == PFX_CTRL) begin
      if (b1 == SYNC_BYTE)      op = OP_ENABLE;
      else if (b1 == ERASE_SEL) op = OP_ERASE;
    end else if ({b0[7:4], b0[2:0]} == 7'b0010_000) op = OP_RD_PROG;
    else if ({b0[7:4], b0[2:0]} == 7'b0100_000)     op = OP_WR_PROG;
    else if (b0 == RD_DATA)                         op = OP_RD_DATA;
    else if (b0 == WR_DATA)                         op = OP_WR_DATA;
    return op;
  endfunction
endpackage

// File: rtl/isp_sck_sync.sv
module isp_sck_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sck_i,
  input  logic mosi_i,
  output logic sck_rise_o,
  output logic sck_fall_o,
  output logic mosi_o
);
  logic [STAGES-1:0] sck_q, mosi_q;
  logic sck_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sck_q  <= '0;
      mosi_q <= '0;
      sck_d  <= 1'b0;
    end else begin
      sck_q  <= {sck_q[STAGES-2:0], sck_i};
      mosi_q <= {mosi_q[STAGES-2:0], mosi_i};
      sck_d  <= sck_q[STAGES-1];
    end
  end

  assign sck_rise_o = sck_q[STAGES-1] & ~sck_d;
  assign sck_fall_o = ~sck_q[STAGES-1] & sck_d;
  assign mosi_o     = mosi_q[STAGES-1];
endmodule

// File: rtl/isp_shifter.sv
module isp_shifter
  import isp_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             sck_rise_i,
  input  logic             sck_fall_i,
  input  logic             mosi_i,
  input  byte_t            tx_byte_i,
  output logic [IDX_W-1:0] byte_idx_o,
  output instr_t           instr_o,
  output logic             done_o,
  output logic             miso_o
);
  localparam logic [BIT_CW-1:0] LAST_BIT  = BIT_CW'(BYTE_W - 1);
  localparam logic [IDX_W-1:0]  LAST_BYTE = IDX_W'(INSTR_LEN - 1);

  logic [BIT_CW-1:0] bit_cnt_q;
  logic [IDX_W-1:0]  byte_cnt_q;
  logic [BYTE_W-2:0] rx_q;
  byte_t             tx_q;
  instr_t            instr_q;
  logic              done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bit_cnt_q  <= '0;
      byte_cnt_q <= '0;
      rx_q       <= '0;
      tx_q       <= '0;
      instr_q    <= '0;
      done_q     <= 1'b0;
    end else if (!en_i) begin
      bit_cnt_q  <= '0;
      byte_cnt_q <= '0;
      rx_q       <= '0;
      tx_q       <= '0;
      instr_q    <= '0;
      done_q     <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (sck_rise_i) begin
        bit_cnt_q <= bit_cnt_q + 1'b1;
        if (bit_cnt_q == LAST_BIT) begin
          instr_q[byte_cnt_q] <= {rx_q, mosi_i};
          byte_cnt_q <= (byte_cnt_q == LAST_BYTE) ? '0 : byte_cnt_q + 1'b1;
          done_q     <= (byte_cnt_q == LAST_BYTE);
        end else begin
          rx_q <= {rx_q[BYTE_W-3:0], mosi_i};
        end
      end
      // reload at the first fall of a byte so the output never moves on a rise
      if (sck_fall_i) tx_q <= (bit_cnt_q == '0) ? tx_byte_i : {tx_q[BYTE_W-2:0], 1'b0};
    end
  end

  assign byte_idx_o = byte_cnt_q;
  assign instr_o    = instr_q;
  assign done_o     = done_q;
  assign miso_o     = tx_q[BYTE_W-1];

  p_miso_on_fall_r2: assert property (@(posedge clk_i) disable iff (!rst_ni || !en_i)
    ($past(en_i) && !$stable(miso_o)) |-> $past(sck_fall_i));

  p_byte_step_r1: assert property (@(posedge clk_i) disable iff (!rst_ni || !en_i)
    ($past(en_i) && byte_cnt_q != $past(byte_cnt_q)) |-> $past(sck_rise_i && bit_cnt_q == LAST_BIT));
endmodule

// File: rtl/isp_store.sv
module isp_store
  import isp_pkg::*;
#(
  parameter int unsigned PROG_AW   = 11,
  parameter int unsigned DATA_AW   = 8,
  parameter int unsigned WR_CYCLES = 2000
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [IDX_W-1:0] byte_idx_i,
  input  instr_t           instr_i,
  input  logic             done_i,
  output byte_t            tx_byte_o
);
  localparam int unsigned PROG_WORDS = 1 << PROG_AW;
  localparam int unsigned DATA_BYTES = 1 << DATA_AW;
  localparam int unsigned WORD_W     = 2 * BYTE_W;
  localparam int unsigned LOC_AW     = (PROG_AW > DATA_AW) ? PROG_AW : DATA_AW;
  localparam int unsigned BCW        = $clog2(WR_CYCLES + 1);

  typedef struct packed {
    logic              is_prog;
    logic              hi;
    logic [LOC_AW-1:0] addr;
  } loc_t;

  logic [WORD_W-1:0] prog_mem [PROG_WORDS];
  byte_t             data_mem [DATA_BYTES];

  op_e                op;
  logic               hi;
  logic [PROG_AW-1:0] p_addr;
  logic [DATA_AW-1:0] d_addr;
  loc_t               cur_loc, busy_loc_q;
  logic [BCW-1:0]     busy_cnt_q;
  logic               prog_en_q, wr_go;
  logic [WORD_W-1:0]  p_word;

  assign op      = decode_op(instr_i[0], instr_i[1]);
  assign hi      = instr_i[0][3];
  assign p_addr  = PROG_AW'({instr_i[1], instr_i[2]});
  assign d_addr  = DATA_AW'({instr_i[1], instr_i[2]});
  assign cur_loc = (op == OP_RD_PROG || op == OP_WR_PROG) ? loc_t'{1'b1, hi, LOC_AW'(p_addr)}
                                                          : loc_t'{1'b0, 1'b0, LOC_AW'(d_addr)};
  assign wr_go   = done_i && prog_en_q && (op == OP_WR_PROG || op == OP_WR_DATA);
  assign p_word  = prog_mem[p_addr];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prog_en_q  <= 1'b0;
      busy_cnt_q <= '0;
      busy_loc_q <= '0;
    end else begin
      if (!en_i) prog_en_q <= 1'b0;
      else if (done_i && op == OP_ENABLE) prog_en_q <= 1'b1;
      if (wr_go) begin
        busy_cnt_q <= BCW'(WR_CYCLES);
        busy_loc_q <= cur_loc;
      end else if (busy_cnt_q != '0) begin
        busy_cnt_q <= busy_cnt_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i) begin
    if (done_i && prog_en_q) begin
      unique case (op)
        OP_ERASE: begin
          for (int i = 0; i < PROG_WORDS; i++) prog_mem[i] <= '1;
          for (int j = 0; j < DATA_BYTES; j++) data_mem[j] <= '1;
        end
        OP_WR_PROG: begin
          if (hi) prog_mem[p_addr][WORD_W-1:BYTE_W] <= instr_i[3];
          else    prog_mem[p_addr][BYTE_W-1:0]      <= instr_i[3];
        end
        OP_WR_DATA: data_mem[d_addr] <= instr_i[3];
        default: ;
      endcase
    end
  end

  always_comb begin
    tx_byte_o = '0;
    if (byte_idx_i == IDX_W'(2) && op == OP_ENABLE) begin
      tx_byte_o = SYNC_BYTE;
    end else if (byte_idx_i == IDX_W'(3) && prog_en_q) begin
      if (op == OP_RD_PROG)      tx_byte_o = hi ? p_word[WORD_W-1:BYTE_W] : p_word[BYTE_W-1:0];
      else if (op == OP_RD_DATA) tx_byte_o = data_mem[d_addr];
      if ((op == OP_RD_PROG || op == OP_RD_DATA) && busy_cnt_q != '0 && cur_loc == busy_loc_q)
        tx_byte_o = '1;
    end
  end

  p_unlock_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(prog_en_q) |-> $past(done_i && op == OP_ENABLE));

  p_locked_no_write_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_cnt_q != '0 && $past(busy_cnt_q) == '0) |-> $past(prog_en_q));

  p_busy_count_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_cnt_q != '0 && !wr_go) |=> (busy_cnt_q == $past(busy_cnt_q) - 1'b1));
endmodule

// File: rtl/isp_slave.sv
module isp_slave #(
  parameter int unsigned PROG_AW     = 11,
  parameter int unsigned DATA_AW     = 8,
  parameter int unsigned WR_CYCLES   = 2000,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic sck_i,
  input  logic mosi_i,
  output logic miso_o
);
  import isp_pkg::*;

  logic             sck_rise, sck_fall, mosi_s, done;
  logic [IDX_W-1:0] byte_idx;
  instr_t           instr;
  byte_t            tx_byte;

  isp_sck_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .sck_i, .mosi_i,
    .sck_rise_o(sck_rise), .sck_fall_o(sck_fall), .mosi_o(mosi_s)
  );

  isp_shifter u_shift (
    .clk_i, .rst_ni, .en_i,
    .sck_rise_i(sck_rise), .sck_fall_i(sck_fall), .mosi_i(mosi_s),
    .tx_byte_i(tx_byte), .byte_idx_o(byte_idx), .instr_o(instr),
    .done_o(done), .miso_o
  );

  isp_store #(.PROG_AW(PROG_AW), .DATA_AW(DATA_AW), .WR_CYCLES(WR_CYCLES)) u_store (
    .clk_i, .rst_ni, .en_i,
    .byte_idx_i(byte_idx), .instr_i(instr), .done_i(done), .tx_byte_o(tx_byte)
  );
endmodule

// File: tb/tb_isp_slave.sv
module tb_isp_slave;
  localparam int HALF = 8;

  logic clk = 1'b0, rst_ni = 1'b0, en = 1'b0, sck = 1'b0, mosi = 1'b0;
  logic miso;
  int checks = 0, errors = 0;

  typedef struct {
    logic [31:0] exp;
    string       tag;
  } exp_t;
  exp_t q[$];

  always #2.5 clk = ~clk;

  isp_slave dut (.clk_i(clk), .rst_ni(rst_ni), .en_i(en), .sck_i(sck), .mosi_i(mosi), .miso_o(miso));

  task automatic check(input bit ok, input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: got %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      @(negedge clk) mosi = b[i];
      repeat (HALF) @(negedge clk);
      sck = 1'b1;
      repeat (HALF) @(negedge clk);
      sck = 1'b0;
    end
  endtask

  // driver: push expected output bytes, then shift the instruction
  task automatic xfer(input logic [7:0] b0, b1, b2, b3, e3, e4, input string tag);
    exp_t e;
    e.exp = {8'h00, 8'h00, e3, e4};
    e.tag = tag;
    q.push_back(e);
    send_bits(b0, 8); send_bits(b1, 8); send_bits(b2, 8); send_bits(b3, 8);
  endtask

  task automatic pulse_en();
    @(negedge clk) en = 1'b0;
    repeat (6) @(negedge clk);
    check(miso == 1'b0, "R10 miso idle", {7'd0, miso}, 8'h00);
    en = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  // monitor: assemble output bytes and compare against the queue
  initial begin
    logic [31:0] word = '0;
    int nbits = 0;
    exp_t e;
    forever begin
      @(posedge sck or negedge en);
      if (!en) begin
        nbits = 0;
      end else begin
        word = {word[30:0], miso};
        nbits++;
        if (nbits == 32) begin
          nbits = 0;
          if (q.size() == 0) begin
            check(1'b0, "R1 unexpected instruction", word[7:0], 8'h00);
          end else begin
            e = q.pop_front();
            for (int k = 0; k < 4; k++)
              check(word[31-8*k -: 8] == e.exp[31-8*k -: 8], $sformatf("%s byte%0d", e.tag, k + 1),
                    word[31-8*k -: 8], e.exp[31-8*k -: 8]);
          end
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    check(miso == 1'b0, "R11 reset output", {7'd0, miso}, 8'h00);
    rst_ni = 1'b1;
    en = 1'b1;
    repeat (4) @(negedge clk);

    xfer(8'hAC, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, "R1 failed handshake");
    xfer(8'h20, 8'h00, 8'h05, 8'h00, 8'h00, 8'h00, "R4 locked read");
    xfer(8'hAC, 8'h53, 8'h00, 8'h00, 8'h53, 8'h00, "R3 enable echo");
    xfer(8'hAC, 8'h80, 8'h00, 8'h00, 8'h00, 8'h00, "R5 erase");
    xfer(8'h28, 8'h07, 8'hFF, 8'h00, 8'h00, 8'hFF, "R5 prog erased");
    xfer(8'hA0, 8'h00, 8'hFF, 8'h00, 8'h00, 8'hFF, "R5 data erased");

    xfer(8'hC0, 8'h00, 8'h10, 8'h3C, 8'h00, 8'h00, "R11 data write");
    repeat (2500) @(negedge clk);
    xfer(8'hA0, 8'h00, 8'h10, 8'h00, 8'h00, 8'h3C, "R8 data read");

    xfer(8'h40, 8'h05, 8'h23, 8'h5A, 8'h00, 8'h00, "R7 prog write low");
    xfer(8'hA0, 8'h00, 8'h10, 8'h00, 8'h00, 8'h3C, "R9 other location");
    xfer(8'h20, 8'h05, 8'h23, 8'h00, 8'h00, 8'hFF, "R9 poll busy");
    repeat (2500) @(negedge clk);
    xfer(8'h20, 8'h05, 8'h23, 8'h00, 8'h00, 8'h5A, "R9 poll done");
    xfer(8'h28, 8'h05, 8'h23, 8'h00, 8'h00, 8'hFF, "R7 high untouched");
    xfer(8'h48, 8'h05, 8'h23, 8'hA5, 8'h00, 8'h00, "R7 prog write high");
    repeat (2500) @(negedge clk);
    xfer(8'h28, 8'h05, 8'h23, 8'h00, 8'h00, 8'hA5, "R6 read high");
    xfer(8'h20, 8'h05, 8'h23, 8'h00, 8'h00, 8'h5A, "R6 read low");

    xfer(8'hC0, 8'h00, 8'h20, 8'h77, 8'h00, 8'h00, "R8 data write");
    xfer(8'hA0, 8'h00, 8'h20, 8'h00, 8'h00, 8'hFF, "R9 data poll busy");
    repeat (2500) @(negedge clk);
    xfer(8'hA0, 8'h00, 8'h20, 8'h00, 8'h00, 8'h77, "R9 data poll done");

    // abort mid instruction, lock is dropped
    send_bits(8'hC0, 8); send_bits(8'h00, 8); send_bits(8'h10, 4);
    pulse_en();
    xfer(8'hC0, 8'h00, 8'h10, 8'h99, 8'h00, 8'h00, "R4 locked write");
    xfer(8'hA0, 8'h00, 8'h10, 8'h00, 8'h00, 8'h00, "R10 relocked read");
    xfer(8'hAC, 8'h80, 8'h00, 8'h00, 8'h00, 8'h00, "R4 locked erase");
    send_bits(8'hAC, 8); send_bits(8'h53, 5);
    pulse_en();
    xfer(8'hAC, 8'h53, 8'h00, 8'h00, 8'h53, 8'h00, "R10 realigned enable");
    xfer(8'hA0, 8'h00, 8'h10, 8'h00, 8'h00, 8'h3C, "R4 write ignored");
    xfer(8'h20, 8'h05, 8'h23, 8'h00, 8'h00, 8'h5A, "R4 erase ignored");

    xfer(8'hAC, 8'h80, 8'h00, 8'h00, 8'h00, 8'h00, "R5 erase again");
    xfer(8'h20, 8'h05, 8'h23, 8'h00, 8'h00, 8'hFF, "R5 prog cleared");
    xfer(8'hA0, 8'h00, 8'h10, 8'h00, 8'h00, 8'hFF, "R5 data cleared");

    repeat (20) @(negedge clk);
    check(q.size() == 0, "R1 queue drained", 8'(q.size()), 8'h00);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule